// File: doc/BRIEF.md
# Low-Power Mode and Wake-Up Controller

This block holds the processor's power control byte and turns it into clock and oscillator enables. Software enters a light sleep, where only the CPU clock is gated, or a deep sleep, where the CPU, the peripherals and the oscillator all stop. A pending interrupt ends either state. A configuration bit decides whether that interrupt must be enabled, or whether any raised request flag is enough. When either sleep state ends, the hardware clears both sleep bits and raises a one-cycle resume strobe. The core then carries on with the instruction that follows the one that put it to sleep.

There is also a hardware-triggered shutdown. When it is armed, a high-to-low transition on the power-fail input stops the oscillator. Only a qualified reset leaves this state. The reset pin is qualified as well: it only takes effect after it has stayed high for a full machine cycle. The same byte stores two general-purpose flags and the serial baud-doubling bit. The serial bit is also brought out as a pin.

All enables are level outputs. The block has no streaming data path, so it has no handshake. A register write is a single-cycle strobe, and it is always accepted except during the hardware shutdown.

Top module: `pwr_mode_ctl`

## Requirements
- R1: After power-on reset, the register reads 8'h10, and cpu_clk_en, periph_clk_en and osc_run are all 1.
- R2: Bit 4 of the register always reads 1, whatever value was written.
- R3: Writing bit 0 = 1 (light sleep) with bit 1 = 0 drives cpu_clk_en to 0 and keeps periph_clk_en and osc_run at 1.
- R4: Writing bit 1 = 1 (deep sleep) drives cpu_clk_en, periph_clk_en and osc_run to 0.
- R5: Writing bits 1:0 = 2'b11 gives deep sleep: the register then reads bits 1:0 = 2'b10.
- R6: With bit 5 (wake-on-any-flag) = 0, only a raised flag whose enable bit is set ends a sleep state. A flag with a cleared enable bit leaves the sleep bits unchanged.
- R7: With bit 5 = 1, any raised flag ends a sleep state, whether or not it is enabled. Bit 5 keeps its value afterwards.
- R8: Waking clears bits 1:0, restores every enable, and pulses resume high for exactly one cycle. That cycle is the same cycle in which bits 1:0 first read 0.
- R9: With bit 6 (shutdown arm) = 1, a falling edge on pfail_pin drives all three enables to 0. Interrupt flags and register writes then leave the enables and the register unchanged until a qualified reset.
- R10: While bit 6 = 0, a falling edge on pfail_pin has no effect.
- R11: A high pulse on rst_pin lasting MC_CYCLES-1 clock cycles is ignored. A pulse of MC_CYCLES or more clock cycles raises sys_rst, clears the register to 8'h10 and ends the shutdown.
- R12: Bits 7, 3 and 2 store the written values, and serial_dbl follows bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin | input | 1 | Raw reset pin, active high, qualified internally |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| irq_flags | input | IRQ_N | Per-source interrupt request flags |
| irq_en | input | IRQ_N | Per-source interrupt enables |
| pfail_pin | input | 1 | Power-fail detect pin, asynchronous |
| rd_data | output | 8 | Register read value |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Timer, serial and interrupt logic clock enable |
| osc_run | output | 1 | Oscillator run request |
| resume | output | 1 | One-cycle wake strobe |
| serial_dbl | output | 1 | Serial baud-doubling select |
| sys_rst | output | 1 | Qualified reset |

## Verification
The wake logic is swept over every interrupt source, both sleep depths, both values of the wake-on-any-flag bit, and both a matched and a mismatched enable. For the mismatched enable, every other source is enabled, so a design that ORs the flags and the enables apart from each other would be caught. Those cases show which wake decisions depend on the enable mask and which ignore it. The power-fail edge is tried with the shutdown unarmed and then armed. It is followed by interrupts and writes that must not end the shutdown. The reset pin is pulsed one cycle short of the qualification length, and then long enough, which separates the two sides of that threshold.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  // Field layout of the power control byte; bit order is decoded by the core.
  typedef struct packed {
    logic dbl;       // 7 serial baud doubling
    logic hpd_arm;   // 6 hardware shutdown arm
    logic wake_any;  // 5 any raised flag wakes
    logic rsvd;      // 4 reads as one
    logic gf1;       // 3
    logic gf0;       // 2
    logic deep;      // 1 deep sleep
    logic light;     // 0 light sleep
  } pwr_reg_t;

  localparam logic [7:0] RSVD_MASK = 8'h10;
endpackage

// File: rtl/pwr_pin_sync.sv
module pwr_pin_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1, s2;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= d;
      s2 <= s1;
    end
  end

  assign q = s2;
endmodule

// File: rtl/pwr_rst_qual.sv
module pwr_rst_qual #(
  parameter int MC_CYCLES = 12
) (
  input  logic clk,
  input  logic por_n,
  input  logic pin_s,
  output logic rst_q
);
  localparam int CW = $clog2(MC_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MC_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          cnt <= '0;
    else if (!pin_s)     cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign rst_q = (cnt == LIMIT);
endmodule

// File: rtl/pwr_fail_det.sv
module pwr_fail_det (
  input  logic clk,
  input  logic por_n,
  input  logic pin_s,
  input  logic arm,
  output logic fall
);
  logic prev;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) prev <= 1'b0;
    else        prev <= pin_s;
  end

  assign fall = arm & prev & ~pin_s;
endmodule

// File: rtl/pwr_mode_core.sv
module pwr_mode_core
  import pwr_pkg::*;
#(
  parameter int IRQ_N = 6
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             sys_rst,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic [IRQ_N-1:0] irq_flags,
  input  logic [IRQ_N-1:0] irq_en,
  input  logic             fall,
  output pwr_reg_t         reg_q,
  output logic             hpd_q,
  output logic             resume_q
);
  pwr_reg_t wr_val;
  logic     sleeping;
  logic     wake;

  always_comb begin
    wr_val       = pwr_reg_t'(wr_data);
    wr_val.rsvd  = 1'b0;
    wr_val.light = wr_data[0] & ~wr_data[1];
  end

  assign sleeping = reg_q.light | reg_q.deep;
  assign wake     = reg_q.wake_any ? (|irq_flags) : (|(irq_flags & irq_en));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      reg_q    <= '0;
      hpd_q    <= 1'b0;
      resume_q <= 1'b0;
    end else if (sys_rst) begin
      reg_q    <= '0;
      hpd_q    <= 1'b0;
      resume_q <= 1'b0;
    end else begin
      resume_q <= 1'b0;
      if (fall) hpd_q <= 1'b1;
      if (!hpd_q) begin
        if (wr_en) begin
          reg_q <= wr_val;
        end else if (sleeping && wake) begin
          reg_q.light <= 1'b0;
          reg_q.deep  <= 1'b0;
          resume_q    <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
  import pwr_pkg::*;
#(
  parameter int IRQ_N     = 6,
  parameter int MC_CYCLES = 12
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_pin,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic [IRQ_N-1:0] irq_flags,
  input  logic [IRQ_N-1:0] irq_en,
  input  logic             pfail_pin,
  output logic [7:0]       rd_data,
  output logic             cpu_clk_en,
  output logic             periph_clk_en,
  output logic             osc_run,
  output logic             resume,
  output logic             serial_dbl,
  output logic             sys_rst
);
  logic [1:0] pins_s;
  logic       fall;
  pwr_reg_t   reg_q;
  logic       hpd_q;
  logic       stopped;

  pwr_pin_sync #(.W(2)) u_sync (
    .clk(clk), .por_n(por_n), .d({pfail_pin, rst_pin}), .q(pins_s)
  );

  pwr_rst_qual #(.MC_CYCLES(MC_CYCLES)) u_rstq (
    .clk(clk), .por_n(por_n), .pin_s(pins_s[0]), .rst_q(sys_rst)
  );

  pwr_fail_det u_fail (
    .clk(clk), .por_n(por_n), .pin_s(pins_s[1]), .arm(reg_q.hpd_arm), .fall(fall)
  );

  pwr_mode_core #(.IRQ_N(IRQ_N)) u_core (
    .clk(clk), .por_n(por_n), .sys_rst(sys_rst), .wr_en(wr_en), .wr_data(wr_data),
    .irq_flags(irq_flags), .irq_en(irq_en), .fall(fall),
    .reg_q(reg_q), .hpd_q(hpd_q), .resume_q(resume)
  );

  assign stopped       = reg_q.deep | hpd_q;
  assign osc_run       = ~stopped;
  assign periph_clk_en = ~stopped;
  assign cpu_clk_en    = ~(stopped | reg_q.light);
  assign serial_dbl    = reg_q.dbl;
  assign rd_data       = reg_q | RSVD_MASK;
endmodule

// File: rtl/pwr_mode_ctl_chk.sv
module pwr_mode_ctl_chk #(
  parameter int IRQ_N = 6
) (
  input logic             clk,
  input logic             por_n,
  input logic             wr_en,
  input logic [7:0]       wr_data,
  input logic [IRQ_N-1:0] irq_flags,
  input logic [IRQ_N-1:0] irq_en,
  input logic [7:0]       rd_data,
  input logic             cpu_clk_en,
  input logic             periph_clk_en,
  input logic             osc_run,
  input logic             resume,
  input logic             sys_rst
);
  // R2
  rsvd_one_chk: assert property (@(posedge clk) disable iff (!por_n)
    rd_data[4]);

  // R4
  osc_gate_chk: assert property (@(posedge clk) disable iff (!por_n)
    !osc_run |-> (!cpu_clk_en && !periph_clk_en));

  // R8
  resume_pulse_chk: assert property (@(posedge clk) disable iff (!por_n || sys_rst)
    resume |=> !resume);

  // R8
  resume_clear_chk: assert property (@(posedge clk) disable iff (!por_n || sys_rst)
    resume |-> (rd_data[1:0] == 2'b00 && cpu_clk_en && osc_run));

  // R5
  deep_wins_chk: assert property (@(posedge clk) disable iff (!por_n || sys_rst)
    (wr_en && wr_data[1:0] == 2'b11 && osc_run) |=> (rd_data[1:0] == 2'b10));

  // R6
  masked_hold_chk: assert property (@(posedge clk) disable iff (!por_n || sys_rst)
    (rd_data[1:0] != 2'b00 && !rd_data[5] && (irq_flags & irq_en) == '0 && !wr_en)
      |=> (rd_data[1:0] == $past(rd_data[1:0])));

  // R9
  shutdown_hold_chk: assert property (@(posedge clk) disable iff (!por_n || sys_rst)
    (!osc_run && !rd_data[1]) |=> !osc_run);
endmodule

bind pwr_mode_ctl pwr_mode_ctl_chk #(.IRQ_N(IRQ_N)) u_chk (
  .clk(clk), .por_n(por_n), .wr_en(wr_en), .wr_data(wr_data),
  .irq_flags(irq_flags), .irq_en(irq_en), .rd_data(rd_data),
  .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .osc_run(osc_run),
  .resume(resume), .sys_rst(sys_rst)
);

// File: tb/pwr_mode_ctl_test.sv
module pwr_mode_ctl_test;
  localparam int IRQ_N = 6;
  localparam int MC    = 12;

  logic             clk = 1'b0;
  logic             por_n = 1'b0;
  logic             rst_pin = 1'b0;
  logic             wr_en = 1'b0;
  logic [7:0]       wr_data = '0;
  logic [IRQ_N-1:0] irq_flags = '0;
  logic [IRQ_N-1:0] irq_en = '0;
  logic             pfail_pin = 1'b1;
  logic [7:0]       rd_data;
  logic             cpu_clk_en, periph_clk_en, osc_run, resume, serial_dbl, sys_rst;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  pwr_mode_ctl #(.IRQ_N(IRQ_N), .MC_CYCLES(MC)) uut (
    .clk(clk), .por_n(por_n), .rst_pin(rst_pin), .wr_en(wr_en), .wr_data(wr_data),
    .irq_flags(irq_flags), .irq_en(irq_en), .pfail_pin(pfail_pin),
    .rd_data(rd_data), .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
    .osc_run(osc_run), .resume(resume), .serial_dbl(serial_dbl), .sys_rst(sys_rst)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic steps(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic write_reg(input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    steps(2);
    por_n = 1'b1;
    steps(2);
    // R1
    check("R1 rd", rd_data, 8'h10);
    check("R1 en", {cpu_clk_en, periph_clk_en, osc_run, sys_rst}, 4'b1110);

    // R12 and R2
    write_reg(8'b1000_1100);
    check("R12 rd", rd_data, 8'h9C);
    check("R12 dbl", serial_dbl, 1'b1);
    write_reg(8'h00);
    check("R2 rd", rd_data, 8'h10);
    check("R12 dbl off", serial_dbl, 1'b0);

    // R5: both sleep bits written
    write_reg(8'h03);
    check("R5 bits", rd_data[1:0], 2'b10);
    check("R5 en", {cpu_clk_en, periph_clk_en, osc_run}, 3'b000);
    write_reg(8'h00);

    // R3 R4 R6 R7 R8 sweep
    for (int m = 0; m < 2; m++)
      for (int w = 0; w < 2; w++)
        for (int e = 0; e < 2; e++)
          for (int i = 0; i < IRQ_N; i++) begin
            logic [7:0] v;
            logic [IRQ_N-1:0] bitm;
            logic exp_wake;
            v = {2'b00, w[0], 3'b000, m[0], ~m[0]};
            bitm = IRQ_N'(1) << i;
            exp_wake = w[0] | e[0];
            write_reg(v);
            if (m == 0) check("R3 light en", {cpu_clk_en, periph_clk_en, osc_run}, 3'b011);
            else        check("R4 deep en", {cpu_clk_en, periph_clk_en, osc_run}, 3'b000);
            irq_en = e[0] ? bitm : ~bitm;
            irq_flags = bitm;
            @(negedge clk);
            if (exp_wake) begin
              check(w[0] ? "R7 wake" : "R6 wake", {resume, rd_data[1:0], cpu_clk_en, osc_run}, 5'b10011);
              check("R7 keep", rd_data[5], w[0]);
            end else begin
              check("R6 hold", {resume, rd_data[1:0]}, {1'b0, m[0], ~m[0]});
            end
            irq_flags = '0;
            @(negedge clk);
            check("R8 pulse", resume, 1'b0);
            write_reg(8'h00);
            irq_en = '0;
          end

    // R10: unarmed power-fail edge
    pfail_pin = 1'b0;
    steps(5);
    check("R10 ignore", {osc_run, rd_data}, {1'b1, 8'h10});
    pfail_pin = 1'b1;
    steps(3);

    // R9: armed shutdown
    write_reg(8'h40);
    pfail_pin = 1'b0;
    steps(5);
    check("R9 stop", {cpu_clk_en, periph_clk_en, osc_run}, 3'b000);
    irq_en = '1;
    irq_flags = '1;
    write_reg(8'h00);
    steps(3);
    check("R9 hold", {osc_run, resume, rd_data}, {2'b00, 8'h50});
    irq_flags = '0;
    irq_en = '0;

    // R11: short reset pulse ignored
    rst_pin = 1'b1;
    for (int k = 0; k < MC - 1; k++) begin
      @(negedge clk);
      if (sys_rst) check("R11 short", sys_rst, 1'b0);
    end
    rst_pin = 1'b0;
    steps(4);
    check("R11 short", {sys_rst, osc_run, rd_data}, {2'b00, 8'h50});

    // R11: long reset pulse qualifies
    rst_pin = 1'b1;
    steps(MC + 4);
    check("R11 long rst", sys_rst, 1'b1);
    rst_pin = 1'b0;
    pfail_pin = 1'b1;
    steps(4);
    check("R11 clear", {sys_rst, cpu_clk_en, osc_run, rd_data}, {3'b011, 8'h10});

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 50000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule